// File: doc/BRIEF.md
# Rising Edge Tick Detector

This block watches a slowly changing single-bit input and produces a tick that lasts one update period each time the input goes from low to high. The machine is a three-state Moore design. Its states are input-low, edge-seen and input-high, and the tick is high only in edge-seen. The state does not move on every system clock. A free-running prescaler inside the block raises a one-cycle step enable once every 2^PRESCALE_W system cycles, and the state register takes its next value only on that enable. Each tick therefore stays high for a full update period, which is long enough to see on an LED.

The monitored input passes through a synchronizer chain before the state machine samples it. The tick is a registered output. A synchronous active-high reset clears the prescaler, the synchronizer and the state.

Top module: `rise_tick_detector`

## Requirements
- R1: While `rst` is high at a clock edge, the following cycle shows `tick_o` low, the state is input-low and the prescaler restarts from zero. After release, a high input produces a tick at the first update even if the block was in input-high before the reset.
- R2: State updates happen only at the system-clock edges that lie a whole multiple of P = 2^PRESCALE_W cycles after the first edge with `rst` low. `tick_o` does not change between those edges.
- R3: A high sample taken at an update while the machine is in input-low (state code 0) moves it to edge-seen (code 1). `tick_o` is then high for exactly P system cycles.
- R4: From edge-seen, a high sample moves to input-high (code 2). While the samples stay high, the machine stays in input-high and gives no further tick.
- R5: A low sample at any update returns the machine to input-low with `tick_o` low. A low, high, low, high sequence of samples gives two separate ticks.
- R6: Every sequence of six per-period samples that starts from reset gives the tick pattern that the state rules above predict.
- R7: An update uses the input value that was present at the system-clock edge two cycles before the update edge. A change made after that edge is used only by the next update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sig_in | input | 1 | Monitored slow input, asynchronous to clk |
| tick_o | output | 1 | High for one update period after a low-to-high change |

## Verification
The hardest case to reach is the capture window. The input has to change in exactly the cycle that decides whether an update sees the new value, which is two cycles before the update edge. The bench keeps its own cycle count from the release of reset. It places input changes one cycle before that edge and exactly on it, and expects the tick at that update in the first case and one update later in the second. The bench also resets the block while it sits in input-high with the input still high. It then sweeps all 64 six-period sample sequences from reset, on a three-bit prescaler, against a state model written from the requirements.

// File: rtl/rise_tick_pkg.sv
package rise_tick_pkg;

  // The encoding matters: code 3 is unused and recovers to TS_LOW.
  typedef enum logic [1:0] {
    TS_LOW  = 2'd0,
    TS_EDGE = 2'd1,
    TS_HIGH = 2'd2
  } tick_state_e;

endpackage

// File: rtl/rise_tick_prescaler.sv
module rise_tick_prescaler #(
  parameter int unsigned PRESCALE_W = 16
) (
  input  logic clk,
  input  logic rst,
  output logic step_o
);

  localparam logic [PRESCALE_W-1:0] CNT_LAST = {PRESCALE_W{1'b1}};
  localparam logic [PRESCALE_W-1:0] CNT_PRE  = CNT_LAST - 1'b1;

  logic [PRESCALE_W-1:0] cnt_q;

  // Free-running wrap counter.
  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_q + 1'b1;
  end

  // Registered enable. It is high in the cycle where the count holds its last value.
  always_ff @(posedge clk) begin
    if (rst) step_o <= 1'b0;
    else     step_o <= (cnt_q == CNT_PRE);
  end

endmodule

// File: rtl/rise_tick_sync.sv
module rise_tick_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] pipe_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) pipe_q[0] <= 1'b0;
        else     pipe_q[0] <= d_i;
      end
    end else begin : g_rest
      always_ff @(posedge clk) begin
        if (rst) pipe_q[i] <= 1'b0;
        else     pipe_q[i] <= pipe_q[i-1];
      end
    end
  end

  assign q_o = pipe_q[STAGES-1];

endmodule

// File: rtl/rise_tick_fsm.sv
module rise_tick_fsm
  import rise_tick_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        step_i,
  input  logic        level_i,
  output tick_state_e state_o,
  output logic        tick_o
);

  tick_state_e state_d;

  // Next-state process.
  always_comb begin
    case (state_o)
      TS_LOW:  state_d = level_i ? TS_EDGE : TS_LOW;
      TS_EDGE: state_d = level_i ? TS_HIGH : TS_LOW;
      TS_HIGH: state_d = level_i ? TS_HIGH : TS_LOW;
      default: state_d = TS_LOW;
    endcase
  end

  // State and the registered Moore output change only on a step.
  always_ff @(posedge clk) begin
    if (rst) begin
      state_o <= TS_LOW;
      tick_o  <= 1'b0;
    end else if (step_i) begin
      state_o <= state_d;
      tick_o  <= (state_d == TS_EDGE);
    end
  end

endmodule

// File: rtl/rise_tick_detector.sv
module rise_tick_detector
  import rise_tick_pkg::*;
#(
  parameter int unsigned PRESCALE_W  = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sig_in,
  output logic tick_o
);

  logic        step;
  logic        level_sync;
  tick_state_e fsm_state;

  rise_tick_prescaler #(.PRESCALE_W(PRESCALE_W)) u_prescale (
    .clk    (clk),
    .rst    (rst),
    .step_o (step)
  );

  rise_tick_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (sig_in),
    .q_o (level_sync)
  );

  rise_tick_fsm u_fsm (
    .clk     (clk),
    .rst     (rst),
    .step_i  (step),
    .level_i (level_sync),
    .state_o (fsm_state),
    .tick_o  (tick_o)
  );

endmodule

// File: rtl/rise_tick_chk.sv
module rise_tick_chk
  import rise_tick_pkg::*;
#(
  parameter int unsigned PRESCALE_W = 16
) (
  input logic        clk,
  input logic        rst,
  input logic        step,
  input logic        level,
  input tick_state_e state,
  input logic        tick_o
);

  localparam int unsigned PERIOD = 1 << PRESCALE_W;
  localparam int unsigned RUN_W  = PRESCALE_W + 2;

  // Counts consecutive earlier cycles with the tick high. It saturates.
  logic [RUN_W-1:0] run_q;
  always_ff @(posedge clk) begin
    if (rst || !tick_o)            run_q <= '0;
    else if (run_q != {RUN_W{1'b1}}) run_q <= run_q + 1'b1;
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> (!tick_o && state == TS_LOW));

  // R2
  hold_between_updates_chk: assert property (@(posedge clk) disable iff (rst)
    !step |=> ($stable(tick_o) && $stable(state)));

  // R2
  step_single_chk: assert property (@(posedge clk) disable iff (rst) step |=> !step);

  // R3
  edge_tick_chk: assert property (@(posedge clk) disable iff (rst)
    (step && state == TS_LOW && level) |=> (tick_o && state == TS_EDGE));

  // R3
  tick_len_chk: assert property (@(posedge clk) disable iff (rst)
    tick_o |-> (run_q < RUN_W'(PERIOD)));

  // R4
  held_high_chk: assert property (@(posedge clk) disable iff (rst)
    (step && state != TS_LOW && level) |=> (!tick_o && state == TS_HIGH));

  // R5
  low_input_chk: assert property (@(posedge clk) disable iff (rst)
    (step && !level) |=> (!tick_o && state == TS_LOW));

endmodule

bind rise_tick_detector rise_tick_chk #(.PRESCALE_W(PRESCALE_W)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .step   (step),
  .level  (level_sync),
  .state  (fsm_state),
  .tick_o (tick_o)
);

// File: tb/test_rise_tick_detector.sv
module test_rise_tick_detector;

  localparam int CLK_PERIOD = 10;
  localparam int PW         = 3;
  localparam int P          = 1 << PW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sig_in = 1'b0;
  logic tick_o;

  int    n_cmp = 0;
  int    n_bad = 0;
  bit    checking = 1'b0;
  bit    done = 1'b0;
  string tag = "R1";

  // Bench model, written from the requirements.
  int       cyc = 0;
  logic     h0 = 1'b0, h1 = 1'b0;
  int       m_state = 0;   // 0 low, 1 edge-seen, 2 high
  logic     m_tick = 1'b0;

  rise_tick_detector #(.PRESCALE_W(PW)) i_rise_tick_detector (
    .clk    (clk),
    .rst    (rst),
    .sig_in (sig_in),
    .tick_o (tick_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (rst) begin
      cyc = 0; h0 = 1'b0; h1 = 1'b0; m_state = 0; m_tick = 1'b0;
    end else begin
      cyc = cyc + 1;
      if (cyc % P == 0) begin
        // R7: h1 holds the input seen two edges before this update edge
        if (!h1)               m_state = 0;
        else if (m_state == 0) m_state = 1;
        else                   m_state = 2;
        m_tick = (m_state == 1);
      end
      h1 = h0;
      h0 = sig_in;
    end
  end

  always @(negedge clk) begin
    if (checking) begin
      n_cmp++;
      if (tick_o !== m_tick) begin
        n_bad++;
        $display("FAIL %s tick_o=%0b expected=%0b at cycle %0d", tag, tick_o, m_tick, cyc);
      end
    end
  end

  task automatic wait_neg(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input int n);
    rst = 1'b1;
    wait_neg(n);
    rst = 1'b0;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    // R1: the reset state, with the input high during reset
    tag = "R1";
    sig_in = 1'b1;
    wait_neg(1);
    checking = 1'b1;
    do_reset(4);
    sig_in = 1'b0;
    // R5: input low, no tick
    tag = "R5";
    wait_neg(3*P);
    // R3: a rising edge gives one period of tick
    tag = "R3";
    sig_in = 1'b1;
    wait_neg(2*P);
    // R4: held high, no second tick
    tag = "R4";
    wait_neg(3*P);
    // R5: low, high, low, high gives two ticks
    tag = "R5";
    sig_in = 1'b0; wait_neg(P);
    sig_in = 1'b1; wait_neg(P);
    sig_in = 1'b0; wait_neg(P);
    sig_in = 1'b1; wait_neg(2*P);
    // R1: reset while in input-high with the input high, then a tick again
    tag = "R1";
    do_reset(2);
    wait_neg(3*P);
    // R6: all six-period sample sequences from reset
    tag = "R6";
    for (int s = 0; s < 64; s++) begin
      sig_in = 1'b0;
      do_reset(2);
      for (int b = 0; b < 6; b++) begin
        sig_in = s[b];
        wait_neg(P);
      end
    end
    // R7: capture window, early change (one cycle before the window edge)
    tag = "R7";
    sig_in = 1'b0;
    do_reset(2);
    wait_neg(2*P);      // just after edge 2P
    wait_neg(P-3);      // just after edge 3P-3
    sig_in = 1'b1;      // present at edge 3P-2, so the update at 3P sees it
    wait_neg(3 + P);
    sig_in = 1'b0;
    wait_neg(2*P);      // just after edge 6P
    // R7: late change, made right after the window edge
    wait_neg(P-2);      // just after edge 7P-2
    sig_in = 1'b1;      // missed at 7P, used at 8P
    wait_neg(2 + 2*P);
    sig_in = 1'b0;
    wait_neg(P);
    checking = 1'b0;
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #(CLK_PERIOD*150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      summary();
      $finish;
    end
  end

endmodule